// File: doc/BRIEF.md
# Dual-Source PWM Duty Generator

This block produces the single gate-enable that chops the low-side switches of a three-phase fan bridge. A free-running sawtooth counter sets the carrier period. The on-time in each period can come from two sources. The first is a numeric control word. It is mapped through a dead band at each end onto a duty threshold, and that threshold is compared against the counter. The second is an external active-low pulse stream. It is synchronised and then passed straight through to the output.

To use the numeric source, the external input is held low. To use the pulse source, the control word is held at its full-on level. A sensed overcurrent turns the output off in the same cycle and keeps it off for the rest of the carrier period. A global enable gates everything.

The threshold is updated only at a period boundary, so a change of the control word never cuts a period short or stretches it.

Top module: `pwm_duty_gen`

## Requirements
- R1: While reset is low, `pwm_on` is 0. Reset clears the counter and the threshold to 0 and sets every synchroniser stage of the pulse input to 1 (off).
- R2: With control word c, the threshold is 0 when c <= LO_EDGE. It is the full period P = 2**CNT_W when c >= HI_EDGE. Otherwise it is floor((c - LO_EDGE) * P / (HI_EDGE - LO_EDGE)). Over any whole period the output is high for exactly that many cycles.
- R3: Within a period, the on-cycles are the first ones: the output is high exactly while the counter value is below the threshold.
- R4: `pwm_in_n` is active-low and passes through SYNC_N register stages. A value driven on it shows at `pwm_on` (inverted) after SYNC_N rising edges, and the output is high only while the synchronised value is 0.
- R5: When the pulse input is held high, as an undriven input reads, the output stays at 0 for any control word.
- R6: When `oc_flag` is high, `pwm_on` is 0 in that same cycle.
- R7: After `oc_flag` is seen, the output stays 0 until the counter wraps to 0. The output is re-armed at the start of the next period, even when the overcurrent fell in the last cycle of a period.
- R8: When `drive_en` is 0, `pwm_on` is 0 in that same cycle. Restoring it resumes normal output at once.
- R9: A new control word takes effect only at the next counter wrap. The threshold is constant within a period.
- R10: The duty never decreases as the control word increases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one counter step per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to clk |
| ctrl_val | input | CTRL_W | Numeric duty request (higher gives more on-time) |
| pwm_in_n | input | 1 | External pulse input, low = on |
| oc_flag | input | 1 | Overcurrent sensed in this cycle |
| drive_en | input | 1 | Global drive enable |
| pwm_on | output | 1 | Low-side gate enable |

## Verification
The overcurrent limiter and the period wrap can act in the same cycle. The bench provokes this by raising `oc_flag` exactly when the counter holds its last value, with the control word at full on. It then expects the output low in that cycle and high again in the first cycle of the next period, which shows that the clear of the limiter wins over the set. A second overlap comes from a control-word change made mid-period: the bench requires the old duty to hold until the wrap and the new duty to appear on the very first cycle after it.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

  // Maps a control word to an on-cycle count for one carrier period.
  function automatic int unsigned scale_ctrl(input int unsigned c,
                                             input int unsigned lo,
                                             input int unsigned hi,
                                             input int unsigned full);
    if (c <= lo)      return 0;
    else if (c >= hi) return full;
    else              return ((c - lo) * full) / (hi - lo);
  endfunction

endpackage

// File: rtl/pwm_sawtooth.sv
module pwm_sawtooth #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = (cnt_q == CNT_MAX);

  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == '0));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != CNT_MAX) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/pwm_duty_map.sv
module pwm_duty_map
  import pwm_gen_pkg::*;
#(
  parameter int CTRL_W  = 8,
  parameter int CNT_W   = 8,
  parameter int LO_EDGE = 66,
  parameter int HI_EDGE = 153
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wrap_i,
  output logic              cmp_o
);
  localparam int THR_W  = CNT_W + 1;
  localparam int PERIOD = 1 << CNT_W;

  logic [THR_W-1:0] thr_q, thr_d, thr_new;

  always_comb begin
    thr_new = THR_W'(scale_ctrl({{(32-CTRL_W){1'b0}}, ctrl_i},
                                LO_EDGE, HI_EDGE, PERIOD));
    thr_d   = wrap_i ? thr_new : thr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= '0;
    else        thr_q <= thr_d;
  end

  assign cmp_o = ({1'b0, cnt_i} < thr_q);

  a_r9_thr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(thr_q));

  a_r2_thr_range: assert property (@(posedge clk) disable iff (!rst_n)
    thr_q <= THR_W'(PERIOD));
endmodule

// File: rtl/pwm_in_sync.sv
module pwm_in_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [SYNC_N-1:0] sq, sd;

  always_comb begin
    sd = {sq[SYNC_N-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sq <= '1;
    else        sq <= sd;
  end

  assign dout = sq[SYNC_N-1];
endmodule

// File: rtl/pwm_oc_limit.sv
module pwm_oc_limit (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_i,
  input  logic wrap_i,
  output logic lim_o
);
  logic lim_q, lim_d;

  always_comb begin
    if (wrap_i) lim_d = 1'b0;
    else        lim_d = lim_q | oc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lim_q <= 1'b0;
    else        lim_q <= lim_d;
  end

  assign lim_o = lim_q;
endmodule

// File: rtl/pwm_duty_gen.sv
module pwm_duty_gen #(
  parameter int CTRL_W  = 8,
  parameter int CNT_W   = 8,
  parameter int LO_EDGE = 66,
  parameter int HI_EDGE = 153,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_val,
  input  logic              pwm_in_n,
  input  logic              oc_flag,
  input  logic              drive_en,
  output logic              pwm_on
);
  logic [CNT_W-1:0] cnt;
  logic             wrap, cmp, ext_off, lim;

  pwm_sawtooth #(.CNT_W(CNT_W)) u_saw (
    .clk(clk), .rst_n(rst_n), .cnt_o(cnt), .wrap_o(wrap));

  pwm_duty_map #(.CTRL_W(CTRL_W), .CNT_W(CNT_W),
                 .LO_EDGE(LO_EDGE), .HI_EDGE(HI_EDGE)) u_map (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_val), .cnt_i(cnt),
    .wrap_i(wrap), .cmp_o(cmp));

  pwm_in_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pwm_in_n), .dout(ext_off));

  pwm_oc_limit u_lim (
    .clk(clk), .rst_n(rst_n), .oc_i(oc_flag), .wrap_i(wrap), .lim_o(lim));

  assign pwm_on = cmp & ~ext_off & ~lim & ~oc_flag & drive_en;

  // R6/R7: an overcurrent outside the last cycle silences the next cycle
  a_r7_limit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_flag && !wrap) |=> !pwm_on);

  // R1: the output is low whenever reset is held
  always_comb begin
    if (!rst_n) a_r1_reset_quiet: assert (!pwm_on);
  end
endmodule

// File: tb/test_pwm_duty_gen.sv
module test_pwm_duty_gen;
  localparam int CLK_P  = 10;
  localparam int CTRL_W = 6;
  localparam int CNT_W  = 6;
  localparam int LO     = 16;
  localparam int HI     = 40;
  localparam int P      = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CTRL_W-1:0] ctrl_val = '0;
  logic pwm_in_n = 1'b1;
  logic oc_flag = 1'b0;
  logic drive_en = 1'b1;
  logic pwm_on;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  pwm_duty_gen #(.CTRL_W(CTRL_W), .CNT_W(CNT_W), .LO_EDGE(LO), .HI_EDGE(HI),
                 .SYNC_N(2)) i_pwm_duty_gen (
    .clk(clk), .rst_n(rst_n), .ctrl_val(ctrl_val), .pwm_in_n(pwm_in_n),
    .oc_flag(oc_flag), .drive_en(drive_en), .pwm_on(pwm_on));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic to_phase(input int ph);
    do begin @(negedge clk); end while ((cyc % P) != ph);
  endtask

  function automatic int exp_thr(input int c);
    if (c <= LO) return 0;
    if (c >= HI) return P;
    return ((c - LO) * P) / (HI - LO);
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int prev, ons, mis, bad;
    int hist[$];
    // R1: reset state
    ctrl_val = '1; pwm_in_n = 1'b0;
    repeat (4) tick();
    chk("R1 reset output", pwm_on, 0);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R1 threshold zero after reset", pwm_on, 0);

    // R2, R3, R10: sweep every control word
    prev = -1;
    for (int c = 0; c < (1 << CTRL_W); c++) begin
      ctrl_val = CTRL_W'(c);
      repeat (2 * P) @(negedge clk);
      ons = 0; mis = 0;
      for (int j = 0; j < P; j++) begin
        tick();
        if (pwm_on) ons++;
        if (int'(pwm_on) != int'((cyc % P) < exp_thr(c))) mis++;
      end
      chk($sformatf("R2 duty c=%0d", c), ons, exp_thr(c));
      chk($sformatf("R3 placement c=%0d", c), mis, 0);
      chk($sformatf("R10 monotonic c=%0d", c), int'(ons >= prev), 1);
      prev = ons;
    end

    // R4: pass-through of the pulse input with two-stage latency
    ctrl_val = '1;
    repeat (2 * P) tick();
    hist.push_back(0); hist.push_back(0);
    mis = 0;
    for (int k = 0; k < 150; k++) begin
      @(negedge clk);
      pwm_in_n = ((k % 7) < 3) || ((k % 11) == 5);
      hist.push_back(int'(pwm_in_n));
      #1;
      if (int'(pwm_on) != 1 - hist[k]) mis++;
    end
    chk("R4 pulse path follows inverted input", mis, 0);

    // R5: input held high (undriven level) keeps output off
    pwm_in_n = 1'b1;
    repeat (3) tick();
    ons = 0;
    for (int j = 0; j < P; j++) begin tick(); if (pwm_on) ons++; end
    chk("R5 high input blocks output", ons, 0);
    pwm_in_n = 1'b0;
    repeat (3) tick();

    // R6, R7: overcurrent mid-period
    to_phase(10);
    oc_flag = 1'b1; #1;
    chk("R6 same-cycle cut", pwm_on, 0);
    bad = 0;
    do begin
      @(negedge clk); oc_flag = 1'b0; #1;
      if ((cyc % P) != 0 && pwm_on) bad++;
    end while ((cyc % P) != 0);
    chk("R7 off for rest of period", bad, 0);
    chk("R7 re-armed at period start", pwm_on, 1);

    // R6, R7: overcurrent in the last cycle of a period
    to_phase(P - 1);
    oc_flag = 1'b1; #1;
    chk("R6 cut in last cycle", pwm_on, 0);
    @(negedge clk); oc_flag = 1'b0; #1;
    chk("R7 no carry-over past wrap", pwm_on, 1);

    // R8: global enable
    to_phase(5);
    drive_en = 1'b0; #1;
    chk("R8 disable same cycle", pwm_on, 0);
    ons = 0;
    for (int j = 0; j < P; j++) begin tick(); if (pwm_on) ons++; end
    chk("R8 disabled period", ons, 0);
    @(negedge clk); drive_en = 1'b1; #1;
    chk("R8 re-enable", pwm_on, 1);

    // R9: control change waits for the wrap
    ctrl_val = '0;
    repeat (2 * P) tick();
    to_phase(20);
    ctrl_val = '1;
    bad = 0;
    do begin
      tick();
      if ((cyc % P) != 0 && pwm_on) bad++;
    end while ((cyc % P) != 0);
    chk("R9 old duty held until wrap", bad, 0);
    chk("R9 new duty at period start", pwm_on, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule